// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a general-purpose counter of parameterized width (32 bits by default). Software reaches it over a simple word-addressed register bus. The count advances on a tick. The tick is made by passing a selected event source through a power-of-two divider. The event source is either the core clock or a synchronized external clock pin. Each tick after the first counts down from a programmed interval to zero. Reaching zero latches a sticky pending flag. The timer then either keeps going, reloading on the next tick, or switches itself off, depending on a mode bit.

When the external pin is the source, the block becomes an up counter. It counts rising edges of the pin, leaves the interval register unused, and flags a pending event when the count wraps to zero. The intended use has these steps:

1. Software clears the current value.
2. Software programs the interval.
3. Software sets the enable bit.
4. Software serves the interrupt line, which rises when the pending flag and its enable are both set.

Top module: `ivl_timer`

## Requirements
- R1: After reset, word 0 (control) reads 0x00000004, words 1 (interval), 2 (current value) and 3 (interrupt) read 0, and `irq` is low.
- R2: A read request on the bus returns the addressed word on `bus_rdata` after the next clock edge. The interval and current-value words read back what was last written. In the control word, bits 31:8 and bit 1 always read 0, and bits 7:2 and bit 0 read back as written.
- R3: The control field at bits 6:4 holds a code n. While enabled, the timer ticks once every 2^n source events, with the first tick on the 2^n-th event after the enable edge. The divider restarts from zero whenever the timer is disabled.
- R4: When control bits 3:2 are 01, the source event is every core clock cycle. On each tick, a current value of 0 loads the interval, and any other value decrements by one.
- R5: When control bit 7 is 0 (continuous), the enable bit (control bit 0) stays set when the count reaches zero, and the next tick reloads the interval.
- R6: When control bit 7 is 1 (single-shot), the enable bit clears itself in the cycle the count reaches zero, and the current value then stays at 0.
- R7: Writing the control word with bit 1 set copies the interval into the current value at that write. The bit is not stored.
- R8: When control bits 3:2 are 10, each rising edge of `ext_clk` is a source event, after a two-flop synchronizer. Each tick increments the current value, and the interval is ignored. A wrap from all ones to zero counts as reaching zero.
- R9: The pending flag (interrupt word bit 1) is set on reaching zero and is cleared by writing the interrupt word with bit 1 set. When a set and a clear fall in the same cycle, the set wins.
- R10: `irq` is a register that is high one cycle after both the pending flag and the interrupt enable (interrupt word bit 0) are set.
- R11: When control bits 3:2 are 00 or 11, no source events occur and the current value holds even while enabled.
- R12: With the internal source and an interval of 0, the count stays at 0 and the pending flag is never set.
- R13: A bus write of the current value takes effect in that cycle even if a tick happens in the same cycle, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 control, 1 interval, 2 current value, 3 interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_clk | input | 1 | Asynchronous external count clock |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can land in the same cycle.

- **Pending set and clear:** the count reaching zero and a software clear of the pending flag. The bench runs a continuous countdown of period four, counts cycles from the enable edge, and places the clear write exactly on the second zero-crossing edge. It then expects the flag to read back as still set. A clear placed one cycle later must read back as cleared.
- **Current-value write and tick:** a bus write of the current value and a tick. The bench overwrites a running count and disables the timer on the following edge. It then expects exactly one decrement from the written value, which shows that the write displaced the colliding tick.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  // word index of each register
  localparam int          REG_AW  = 2;
  localparam logic [1:0]  A_CTRL  = 2'd0;
  localparam logic [1:0]  A_IVAL  = 2'd1;
  localparam logic [1:0]  A_CUR   = 2'd2;
  localparam logic [1:0]  A_IRQ   = 2'd3;

  // control word fields
  localparam int B_EN     = 0;
  localparam int B_RLD    = 1;
  localparam int B_SRC_LO = 2;
  localparam int B_PRE_LO = 4;
  localparam int B_MODE   = 7;

  // interrupt word fields
  localparam int B_IE     = 0;
  localparam int B_PEND   = 1;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_CORE = 2'b01,
    SRC_PIN  = 2'b10,
    SRC_RSV  = 2'b11
  } src_e;

endpackage

// File: rtl/ivl_timer_sync.sv
module ivl_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;

  // a detected edge is a single-cycle pulse
  assert_rise_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/ivl_timer_presc.sv
module ivl_timer_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             evt,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = ~({DIV_W{1'b1}} << sel);
    tick = en && evt && ((cnt_q & mask) == mask);
  end

  // divider restarts whenever the timer is off
  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (evt)   cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    tick |-> (en && evt));
  assert_divider_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/ivl_timer_count.sv
module ivl_timer_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         up_mode,
  input  logic         wr_cur,
  input  logic [W-1:0] wr_data,
  input  logic         reload,
  input  logic [W-1:0] ival,
  output logic [W-1:0] cur,
  output logic         hit
);
  logic [W-1:0] cur_q;
  logic [W-1:0] nxt;

  always_comb begin
    nxt = cur_q;
    hit = 1'b0;
    if (wr_cur) begin
      nxt = wr_data;
    end else if (reload) begin
      nxt = ival;
    end else if (tick) begin
      if (up_mode) begin
        nxt = cur_q + 1'b1;
        hit = (cur_q == {W{1'b1}});
      end else if (cur_q == '0) begin
        nxt = ival;
      end else begin
        nxt = cur_q - 1'b1;
        hit = (cur_q == {{(W-1){1'b0}}, 1'b1});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= '0;
    else     cur_q <= nxt;
  end

  assign cur = cur_q;

  assert_decrement_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !up_mode && !wr_cur && !reload && cur_q != '0) |=> (cur_q == $past(cur_q) - 1'b1));
  assert_up_count_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && up_mode && !wr_cur && !reload) |=> (cur_q == $past(cur_q) + 1'b1));
  assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cur && !reload) |=> $stable(cur_q));
  assert_write_wins_R13: assert property (@(posedge clk) disable iff (rst)
    wr_cur |=> (cur_q == $past(wr_data)));
  assert_reload_copies_R7: assert property (@(posedge clk) disable iff (rst)
    (reload && !wr_cur) |=> (cur_q == $past(ival)));
endmodule

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
  import ivl_timer_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     cur,
  input  logic              hit,
  output logic              en,
  output src_e              src,
  output logic [SEL_W-1:0]  pre,
  output logic [DW-1:0]     ival,
  output logic              wr_cur,
  output logic              reload,
  output logic              irq
);
  localparam int CTRL_USED = B_MODE + 1;

  logic             en_q, single_q, ie_q, pend_q, irq_q;
  src_e             src_q;
  logic [SEL_W-1:0] pre_q;
  logic [DW-1:0]    ival_q, rdata_q;
  logic             wr_any, ctrl_wr, ival_wr, irq_wr;

  always_comb begin
    wr_any  = bus_sel && bus_wr;
    ctrl_wr = wr_any && (bus_addr == A_CTRL);
    ival_wr = wr_any && (bus_addr == A_IVAL);
    irq_wr  = wr_any && (bus_addr == A_IRQ);
    wr_cur  = wr_any && (bus_addr == A_CUR);
    reload  = ctrl_wr && bus_wdata[B_RLD];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      single_q <= 1'b0;
      src_q    <= SRC_CORE;
      pre_q    <= '0;
    end else if (ctrl_wr) begin
      en_q     <= bus_wdata[B_EN];
      single_q <= bus_wdata[B_MODE];
      src_q    <= src_e'(bus_wdata[B_SRC_LO +: 2]);
      pre_q    <= bus_wdata[B_PRE_LO +: SEL_W];
    end else if (hit && single_q) begin
      en_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ival_q <= '0;
    else if (ival_wr) ival_q <= bus_wdata;
  end

  // pending: set beats clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (irq_wr) ie_q <= bus_wdata[B_IE];
      if (hit)                              pend_q <= 1'b1;
      else if (irq_wr && bus_wdata[B_PEND]) pend_q <= 1'b0;
      irq_q <= pend_q && ie_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        A_CTRL: rdata_q <= {{(DW-CTRL_USED){1'b0}}, single_q, pre_q, src_q, 1'b0, en_q};
        A_IVAL: rdata_q <= ival_q;
        A_CUR:  rdata_q <= cur;
        A_IRQ:  rdata_q <= {{(DW-2){1'b0}}, pend_q, ie_q};
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign en        = en_q;
  assign src       = src_q;
  assign pre       = pre_q;
  assign ival      = ival_q;
  assign irq       = irq_q;

  assert_pend_from_hit_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(hit));
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
    hit |=> pend_q);
  assert_single_stops_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && single_q && !ctrl_wr) |=> !en_q);
  assert_continuous_runs_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && !single_q && en_q && !ctrl_wr) |=> en_q);
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(pend_q && ie_q));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PRE_SEL_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_clk,
  output logic              irq
);
  logic                 en, wr_cur, reload, hit, tick, ext_rise, evt, up_mode;
  src_e                 src;
  logic [PRE_SEL_W-1:0] pre;
  logic [CNT_W-1:0]     ival, cur;

  ivl_timer_regs #(.DW(CNT_W), .SEL_W(PRE_SEL_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur(cur), .hit(hit),
    .en(en), .src(src), .pre(pre), .ival(ival),
    .wr_cur(wr_cur), .reload(reload), .irq(irq)
  );

  ivl_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_clk), .rise(ext_rise)
  );

  always_comb begin
    up_mode = (src == SRC_PIN);
    unique case (src)
      SRC_CORE: evt = 1'b1;
      SRC_PIN:  evt = ext_rise;
      default:  evt = 1'b0;
    endcase
  end

  ivl_timer_presc #(.SEL_W(PRE_SEL_W)) u_presc (
    .clk(clk), .rst(rst), .en(en), .evt(evt), .sel(pre), .tick(tick)
  );

  ivl_timer_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .up_mode(up_mode),
    .wr_cur(wr_cur), .wr_data(bus_wdata), .reload(reload),
    .ival(ival), .cur(cur), .hit(hit)
  );

  assert_no_tick_unsourced_R11: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_OFF || src == SRC_RSV) |-> !tick);
endmodule

// File: tb/tb_ivl_timer.sv
module tb_ivl_timer;
  localparam logic [1:0] A_CTRL = 2'd0, A_IVAL = 2'd1, A_CUR = 2'd2, A_IRQ = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        ext_clk = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q = 1'b0;

  always #5 clk = ~clk;

  ivl_timer dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .irq(irq)
  );

  // monitor: a read issued at an edge is compared at the following falling edge
  always @(posedge clk) rd_q <= bus_sel && !bus_wr && !rst;

  always @(negedge clk) begin
    if (rd_q) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: got %08h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: got %08h expected %08h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pin(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic ext_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; idle(3);
      ext_clk = 1'b0; idle(3);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;

    // R1 reset values
    pin(irq, 1'b0, "R1 irq");
    rd(A_CTRL, 32'h4, "R1 ctrl");
    rd(A_IVAL, 32'h0, "R1 ival");
    rd(A_CUR,  32'h0, "R1 cur");
    rd(A_IRQ,  32'h0, "R1 irq word");

    // R2 readback
    wr(A_IVAL, 32'hDEADBEEF);
    rd(A_IVAL, 32'hDEADBEEF, "R2 ival");
    wr(A_CTRL, 32'hFFFFFFF0);
    rd(A_CTRL, 32'h000000F0, "R2 ctrl reserved");
    wr(A_CUR, 32'h12345678);
    rd(A_CUR, 32'h12345678, "R2 cur");

    // R7 reload strobe
    wr(A_CTRL, 32'h4);
    wr(A_IVAL, 32'd55);
    wr(A_CTRL, 32'h6);
    rd(A_CUR, 32'd55, "R7 reload copy");
    rd(A_CTRL, 32'h4, "R7 strobe not stored");

    // R3 / R4 divide by 4: 3 ticks in 12 cycles
    wr(A_CUR, 32'd0);
    wr(A_IVAL, 32'd100);
    wr(A_CTRL, 32'h25);
    idle(11);
    wr(A_CTRL, 32'h24);
    rd(A_CUR, 32'd98, "R3 divide by 4");

    // R4 divide by 1: 10 ticks
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h5);
    idle(9);
    wr(A_CTRL, 32'h4);
    rd(A_CUR, 32'd91, "R4 countdown");

    // R5 continuous with interrupt enabled, R10 irq
    wr(A_IRQ, 32'h3);
    wr(A_IVAL, 32'd3);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h5);
    idle(9);
    pin(irq, 1'b1, "R10 irq high");
    rd(A_CTRL, 32'h5, "R5 still enabled");
    rd(A_IRQ, 32'h3, "R9 pending set");
    wr(A_CTRL, 32'h4);
    wr(A_IRQ, 32'h3);
    idle(1);
    pin(irq, 1'b0, "R10 irq low after clear");
    rd(A_IRQ, 32'h1, "R9 cleared");

    // R9 set and clear in the same cycle
    wr(A_IRQ, 32'h0);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h5);
    idle(7);
    wr(A_IRQ, 32'h2);
    wr(A_CTRL, 32'h4);
    rd(A_IRQ, 32'h2, "R9 set beats clear");
    pin(irq, 1'b0, "R10 masked");
    wr(A_IRQ, 32'h2);
    rd(A_IRQ, 32'h0, "R9 clear alone");

    // R6 single-shot
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h85);
    idle(9);
    rd(A_CTRL, 32'h84, "R6 self disabled");
    rd(A_CUR, 32'd0, "R6 stays zero");
    rd(A_IRQ, 32'h2, "R6 pending");
    wr(A_IRQ, 32'h2);

    // R12 interval zero
    wr(A_IVAL, 32'd0);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h5);
    idle(10);
    wr(A_CTRL, 32'h4);
    rd(A_CUR, 32'd0, "R12 count");
    rd(A_IRQ, 32'h0, "R12 no pending");

    // R11 no source
    wr(A_IVAL, 32'd5);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h1);
    idle(10);
    rd(A_CUR, 32'd0, "R11 source 00");
    wr(A_CTRL, 32'hD);
    idle(10);
    rd(A_CUR, 32'd0, "R11 source 11");
    wr(A_CTRL, 32'h4);

    // R13 write beats tick
    wr(A_IVAL, 32'd1000);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h5);
    idle(5);
    wr(A_CUR, 32'd500);
    wr(A_CTRL, 32'h4);
    rd(A_CUR, 32'd499, "R13 write wins");

    // R8 external edges
    wr(A_CTRL, 32'h8);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h9);
    ext_pulse(5);
    idle(4);
    rd(A_CUR, 32'd5, "R8 up count");
    wr(A_CTRL, 32'h8);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h19);
    ext_pulse(4);
    idle(4);
    rd(A_CUR, 32'd2, "R8 prescaled");
    wr(A_CTRL, 32'h8);
    wr(A_IRQ, 32'h2);
    wr(A_CUR, 32'hFFFFFFFE);
    wr(A_CTRL, 32'h9);
    ext_pulse(2);
    idle(4);
    rd(A_CUR, 32'd0, "R8 wrap");
    rd(A_IRQ, 32'h2, "R8 wrap pending");

    idle(4);
    while (exp_q.size() != 0) @(negedge clk);
    finish_run();
  end
endmodule